// File: doc/BRIEF.md
# Burst Line-Fill Controller

This block moves one whole cache line between a requester and a synchronous SRAM with registered inputs, as a single four-word burst. The requester raises a request and gives one word address, a direction (fill from SRAM or write out to SRAM) and an order flag. The request is taken only while the controller is idle. From then on the controller produces every SRAM address itself from an internal beat counter. The request address is sampled once and is not looked at again during the burst.

The burst follows a 2-1-1-1 rhythm. The first beat takes two clocks and each later beat takes one, so a line is done in five clocks after acceptance. There are two word orders, chosen per burst. The linear order always walks words 0, 1, 2, 3 of the aligned line. The wrap-around order starts at the requested (critical) word and counts up modulo four inside the line. Fill data comes back with a per-beat valid strobe. For write-outs, a per-beat data request asks the requester to present each word in burst order. An acknowledge pulses once, on the final beat.

Top module: `burst_fill_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sram_ce`, `sram_we`, `beat_valid`, `wr_data_req` and `req_ack` are all 0. A reset in the middle of a burst abandons it, and the next burst starts with its beat counter at zero.
- R2: A request is taken only at a clock edge where the controller is idle. A request held high during a burst is ignored. In the cycle after `req_ack` the controller is idle, with `sram_ce`, `beat_valid` and `wr_data_req` all 0.
- R3: For a fill (`req_write`=0) accepted at edge E, cycle 1 after E drives the first word address with `sram_ce`=1 and `sram_we`=0. Cycles 2 to 5 each carry `beat_valid`=1, and `rd_data` holds the word of beats 0 to 3. `beat_valid` and `wr_data_req` are never both 1.
- R4: For a write-out (`req_write`=1), cycle 1 after acceptance has no SRAM access. Cycles 2 to 5 each carry `wr_data_req`=1, `sram_ce`=1 and `sram_we`=1, with the address of beats 0 to 3. `sram_we` is never 1 without `sram_ce`.
- R5: `req_ack` is 1 for exactly one cycle per burst: cycle 5, together with the last beat's strobe.
- R6: With `req_wrap`=1, the word index (address bits [1:0]) of beat k is (start + k) mod 4, where start is `req_addr[1:0]`. Starting at word 2 gives 2, 3, 0, 1. Between consecutive SRAM accesses of one burst, the index steps by +1 mod 4.
- R7: With `req_wrap`=0, beat k uses word index k. The low address bits of the request are ignored.
- R8: Address bits above the word index equal `req_addr[ADDR_W-1:2]` on every access of the burst, and do not change within it.
- R9: During a fill beat, `rd_data` equals the SRAM word stored at that beat's address.
- R10: During a write-out beat, `sram_wdata` equals the `wr_data` presented in that cycle, and that word is stored at the beat's address.
- R11: Changes to `req_addr`, `req_wrap` and `req_write` after acceptance have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request |
| req_addr | input | ADDR_W | Word address of the first (critical) word |
| req_wrap | input | 1 | 1 = wrap-around order, 0 = linear order |
| req_write | input | 1 | 1 = write line out, 0 = fill line |
| req_ack | output | 1 | One-cycle pulse on the final beat |
| beat_valid | output | 1 | Fill data valid on `rd_data` |
| rd_data | output | DATA_W | Fill data for the current beat |
| wr_data_req | output | 1 | Write-out beat: `wr_data` is consumed this cycle |
| wr_data | input | DATA_W | Write-out data for the current beat |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data, valid the cycle after a read access |

## Verification
Some properties are checked on every cycle. The word index steps +1 mod 4 between back-to-back accesses of a burst. The line bits stay frozen within a burst. A linear burst starts at index zero. The acknowledge is a single cycle that always coincides with a beat strobe, and is always followed by an idle cycle. Write enable never appears without chip enable, and fill and write strobes are exclusive. Other behaviour only the bench scenarios can show. These are the exact cycle of each beat relative to acceptance, the absolute start index of a wrap-around burst, and that data written out comes back on a later fill. They also include that requests held or changed mid-burst are ignored, and that a reset in mid-burst leaves the counter cleared. The sweep covers every start word, both orders and both directions on several lines.

// File: rtl/burst_fill_pkg.sv
package burst_fill_pkg;

   // Sequencer phases: idle, the lead cycle of the first beat, then the beat stream.
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LEAD   = 2'd1,
      ST_STREAM = 2'd2
   } burst_phase_e;

endpackage

// File: rtl/burst_fill_seq.sv
module burst_fill_seq
   import burst_fill_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   localparam int LINE_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wrap,
   input  logic              req_write,
   output logic              in_lead,
   output logic              in_stream,
   output logic              last_beat,
   output logic [IDX_W-1:0]  beat_cnt,
   output logic [LINE_W-1:0] line_q,
   output logic [IDX_W-1:0]  start_q,
   output logic              wrap_q,
   output logic              write_q
);

   localparam logic [IDX_W-1:0] LAST_CNT = {IDX_W{1'b1}};

   burst_phase_e phase_q, phase_d;
   logic [IDX_W-1:0] cnt_q, cnt_d;
   logic take;

   assign take = (phase_q == ST_IDLE) && req_valid;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         ST_IDLE: begin
            cnt_d = '0;
            if (req_valid) phase_d = ST_LEAD;
         end
         ST_LEAD: begin
            cnt_d   = '0;
            phase_d = ST_STREAM;
         end
         ST_STREAM: begin
            if (cnt_q == LAST_CNT) begin
               cnt_d   = '0;
               phase_d = ST_IDLE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            cnt_d   = '0;
            phase_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   // Request fields are captured once, on acceptance only.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         start_q <= '0;
         wrap_q  <= 1'b0;
         write_q <= 1'b0;
      end else if (take) begin
         line_q  <= req_addr[ADDR_W-1:IDX_W];
         start_q <= req_addr[IDX_W-1:0];
         wrap_q  <= req_wrap;
         write_q <= req_write;
      end
   end

   assign in_lead   = (phase_q == ST_LEAD);
   assign in_stream = (phase_q == ST_STREAM);
   assign last_beat = in_stream && (cnt_q == LAST_CNT);
   assign beat_cnt  = cnt_q;

endmodule

// File: rtl/burst_fill_addr.sv
module burst_fill_addr #(
   parameter int IDX_W        = 2,
   parameter bit SUPPORT_WRAP = 1'b1
) (
   input  logic             wrap_mode,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] beat_num,
   output logic [IDX_W-1:0] word_idx
);

   generate
      if (SUPPORT_WRAP) begin : g_wrap
         // Modulo-line addition: the carry out of IDX_W bits is dropped.
         logic [IDX_W-1:0] wrapped;
         assign wrapped  = start_idx + beat_num;
         assign word_idx = wrap_mode ? wrapped : beat_num;
      end else begin : g_linear
         logic unused_ok;
         assign unused_ok = wrap_mode ^ (^start_idx);
         assign word_idx  = beat_num;
      end
   endgenerate

endmodule

// File: rtl/burst_fill_issue.sv
module burst_fill_issue #(
   parameter int IDX_W = 2
) (
   input  logic             in_lead,
   input  logic             in_stream,
   input  logic             last_beat,
   input  logic             write_q,
   input  logic [IDX_W-1:0] beat_cnt,
   output logic             issue,
   output logic [IDX_W-1:0] issue_num
);

   // Fills run one beat ahead: the SRAM returns data the cycle after the address.
   // Write-outs place address and data together on the beat itself.
   always_comb begin
      if (write_q) begin
         issue     = in_stream;
         issue_num = beat_cnt;
      end else begin
         issue     = in_lead || (in_stream && !last_beat);
         issue_num = in_lead ? '0 : beat_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/burst_fill_ctrl.sv
module burst_fill_ctrl #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int LINE_WORDS   = 4,
   parameter bit SUPPORT_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wrap,
   input  logic              req_write,
   output logic              req_ack,
   output logic              beat_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              wr_data_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sram_ce,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata,
   input  logic [DATA_W-1:0] sram_rdata
);

   localparam int IDX_W  = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
   localparam int LINE_W = ADDR_W - IDX_W;

   generate
      if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
         $error("LINE_WORDS must be a power of two of at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the word index width");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              in_lead, in_stream, last_beat;
   logic [IDX_W-1:0]  beat_cnt, start_q, issue_num, word_idx;
   logic [LINE_W-1:0] line_q;
   logic              wrap_q, write_q, issue;

   burst_fill_seq #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_wrap  (req_wrap),
      .req_write (req_write),
      .in_lead   (in_lead),
      .in_stream (in_stream),
      .last_beat (last_beat),
      .beat_cnt  (beat_cnt),
      .line_q    (line_q),
      .start_q   (start_q),
      .wrap_q    (wrap_q),
      .write_q   (write_q)
   );

   burst_fill_issue #(
      .IDX_W (IDX_W)
   ) u_issue (
      .in_lead   (in_lead),
      .in_stream (in_stream),
      .last_beat (last_beat),
      .write_q   (write_q),
      .beat_cnt  (beat_cnt),
      .issue     (issue),
      .issue_num (issue_num)
   );

   burst_fill_addr #(
      .IDX_W        (IDX_W),
      .SUPPORT_WRAP (SUPPORT_WRAP)
   ) u_addr (
      .wrap_mode (wrap_q),
      .start_idx (start_q),
      .beat_num  (issue_num),
      .word_idx  (word_idx)
   );

   assign sram_ce     = issue;
   assign sram_we     = issue && write_q;
   assign sram_addr   = {line_q, word_idx};
   assign sram_wdata  = wr_data;
   assign rd_data     = sram_rdata;
   assign beat_valid  = in_stream && !write_q;
   assign wr_data_req = in_stream && write_q;
   assign req_ack     = last_beat;

endmodule

// File: rtl/burst_fill_chk.sv
module burst_fill_chk #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ack,
   input logic              beat_valid,
   input logic              wr_data_req,
   input logic              sram_ce,
   input logic              sram_we,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              cur_wrap
);

   p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   p_ack_on_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (beat_valid || wr_data_req));

   p_idle_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> (!sram_ce && !beat_valid && !wr_data_req));

   p_we_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> (sram_ce && wr_data_req));

   p_dir_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(beat_valid && wr_data_req));

   p_fill_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(beat_valid) |-> ($past(sram_ce) && !$past(sram_we)));

   p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_ce && $past(sram_ce)) |->
         (sram_addr[IDX_W-1:0] == IDX_W'($past(sram_addr[IDX_W-1:0]) + 1'b1)));

   p_line_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_ce && $past(sram_ce)) |->
         (sram_addr[ADDR_W-1:IDX_W] == $past(sram_addr[ADDR_W-1:IDX_W])));

   p_linear_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_ce && !$past(sram_ce) && !cur_wrap) |-> (sram_addr[IDX_W-1:0] == '0));

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!sram_ce && !sram_we && !req_ack);
      end
   end

endmodule

bind burst_fill_ctrl burst_fill_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ack     (req_ack),
   .beat_valid  (beat_valid),
   .wr_data_req (wr_data_req),
   .sram_ce     (sram_ce),
   .sram_we     (sram_we),
   .sram_addr   (sram_addr),
   .cur_wrap    (wrap_q)
);

// File: tb/burst_fill_ctrl_bench.sv
module burst_fill_ctrl_bench;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NWORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_wrap = 1'b0;
   logic          req_write = 1'b0;
   logic          req_ack, beat_valid, wr_data_req;
   logic [DW-1:0] rd_data, sram_wdata, sram_rdata;
   logic [DW-1:0] wr_data = '0;
   logic          sram_ce, sram_we;
   logic [AW-1:0] sram_addr;

   logic [DW-1:0] mem [NWORDS];
   logic [DW-1:0] exp_mem [NWORDS];

   int n_vec = 0;
   int n_bad = 0;
   int gen = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   burst_fill_ctrl #(
      .ADDR_W (AW),
      .DATA_W (DW)
   ) u_burst_fill_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_wrap    (req_wrap),
      .req_write   (req_write),
      .req_ack     (req_ack),
      .beat_valid  (beat_valid),
      .rd_data     (rd_data),
      .wr_data_req (wr_data_req),
      .wr_data     (wr_data),
      .sram_ce     (sram_ce),
      .sram_we     (sram_we),
      .sram_addr   (sram_addr),
      .sram_wdata  (sram_wdata),
      .sram_rdata  (sram_rdata)
   );

   // Synchronous SRAM with registered inputs.
   initial begin
      for (int i = 0; i < NWORDS; i++) begin
         mem[i]     = 32'h1000_0000 + i * 7;
         exp_mem[i] = 32'h1000_0000 + i * 7;
      end
      sram_rdata = '0;
   end

   always @(posedge clk) begin
      if (sram_ce) begin
         if (sram_we) mem[sram_addr] <= sram_wdata;
         else         sram_rdata     <= mem[sram_addr];
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " ce"},     64'(sram_ce),     64'd0);
      chk({tag, " we"},     64'(sram_we),     64'd0);
      chk({tag, " valid"},  64'(beat_valid),  64'd0);
      chk({tag, " wreq"},   64'(wr_data_req), 64'd0);
      chk({tag, " ack"},    64'(req_ack),     64'd0);
   endtask

   function automatic int word_of(input bit wrp, input int start, input int k);
      return wrp ? ((start + k) % 4) : k;
   endfunction

   // One burst. hold_req keeps the request high with other contents while busy (R2, R11).
   task automatic do_burst(input bit wr, input bit wrp, input int line, input int start,
                           input bit hold_req);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'(line * 4 + start);
      req_write = wr;
      req_wrap  = wrp;
      @(negedge clk);                       // cycle 1 after acceptance
      req_valid = hold_req;
      req_addr  = ~req_addr;                 // R11: scramble after acceptance
      req_write = ~wr;
      req_wrap  = ~wrp;
      chk("R5 lead ack", 64'(req_ack), 64'd0);
      chk("R3 lead valid", 64'(beat_valid), 64'd0);
      chk("R4 lead wreq", 64'(wr_data_req), 64'd0);
      if (wr) begin
         chk("R4 lead no access", 64'(sram_ce), 64'd0);
      end else begin
         chk("R3 lead ce", 64'(sram_ce), 64'd1);
         chk("R3 lead we", 64'(sram_we), 64'd0);
         chk("R6 R7 R8 lead addr", 64'(sram_addr), 64'(line * 4 + word_of(wrp, start, 0)));
      end
      for (int k = 0; k < 4; k++) begin
         int e;
         e = line * 4 + word_of(wrp, start, k);
         @(negedge clk);                    // cycle k+2
         chk("R5 ack position", 64'(req_ack), 64'(k == 3));
         if (wr) begin
            logic [DW-1:0] pat;
            pat = 32'hA500_0000 ^ (32'(gen) << 10) ^ 32'(e);
            chk("R4 wreq", 64'(wr_data_req), 64'd1);
            chk("R3 excl valid", 64'(beat_valid), 64'd0);
            wr_data = pat;
            #1;
            chk("R4 ce", 64'(sram_ce), 64'd1);
            chk("R4 we", 64'(sram_we), 64'd1);
            chk("R6 R7 R8 R11 write addr", 64'(sram_addr), 64'(e));
            chk("R10 wdata", 64'(sram_wdata), 64'(pat));
            exp_mem[e] = pat;
         end else begin
            chk("R3 valid", 64'(beat_valid), 64'd1);
            chk("R3 excl wreq", 64'(wr_data_req), 64'd0);
            chk("R9 rd_data", 64'(rd_data), 64'(exp_mem[e]));
            if (k < 3) begin
               chk("R3 ce", 64'(sram_ce), 64'd1);
               chk("R6 R7 R8 R11 read addr", 64'(sram_addr),
                   64'(line * 4 + word_of(wrp, start, k + 1)));
            end else begin
               chk("R3 last no access", 64'(sram_ce), 64'd0);
            end
         end
      end
      @(negedge clk);
      chk_idle("R2 after ack");
      req_valid = 1'b0;
      gen++;
   endtask

   initial begin
      int lines [4] = '{0, 1, 37, 63};
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      chk_idle("R1 after reset");

      // Sweep: every start word, both orders, write-out then fill, several lines.
      foreach (lines[li]) begin
         for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
               do_burst(1'b1, w[0], lines[li], s, 1'b0);
               do_burst(1'b0, w[0], lines[li], (s + 1) % 4, 1'b0);
            end
         end
      end

      // R2, R11: request held high and changed during the whole burst.
      do_burst(1'b0, 1'b1, 9, 2, 1'b1);
      do_burst(1'b1, 1'b1, 9, 3, 1'b1);
      do_burst(1'b0, 1'b0, 9, 1, 1'b1);

      // R1: reset in the middle of a fill, then a clean linear burst.
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'(20 * 4 + 2);
      req_write = 1'b0;
      req_wrap  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_idle("R1 mid-burst reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 stays idle");
      do_burst(1'b0, 1'b0, 20, 2, 1'b0);
      do_burst(1'b0, 1'b1, 20, 2, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule